// File: doc/BRIEF.md
# Configurable MUX2 Tile Array

This block is a small configurable logic array: fifteen identical two-input multiplexer tiles placed on a grid three columns wide and five rows tall. Each tile picks its two data inputs and its select from a short menu of sources. The menu holds constants, the outputs of its four grid neighbours and one inverted neighbour. Seven of the tiles can also pass their result through a flip-flop on the user clock. A flat 120-bit configuration vector, loaded by logic outside this block, sets how every tile is routed.

Along the grid border the missing neighbours are filled in. Tiles on the left and top edges see user input pins in place of a neighbour. Tiles on the right and bottom edges see their own output in place of a neighbour, which makes hold and toggle cells possible when the tile is registered. Eight fabric outputs are taken from the bottom row and the right column. They are always driven, whatever state the external configuration logic is in. The user must not load a configuration that closes an unregistered loop.

Top module: `mux_fabric`

## Requirements
- R1: Configuration bit (frame f, bit b) is `cfg_bits[12*f + b]`. The tile at column x (0..2) and row y (0..4) takes its fields from frames 2y and 2y+1, bits 4x..4x+3. Frame 2y bits 4x+1:4x hold the data-0 route and bits 4x+3:4x+2 hold the data-1 route. Frame 2y+1 bits 4x+1:4x hold the select route, bit 4x+2 inverts the select and bit 4x+3 enables the register. Two-bit fields have the lower bit index as LSB.
- R2: Route codes. Data-0 uses 0 for constant 0, 1 for T, 2 for R and 3 for L. Data-1 uses 0 for constant 1, 1 for NOT L, 2 for B and 3 for R. Select uses 0 for constant 0, 1 for T, 2 for R and 3 for L. T, L, R and B are the tile above, left, right and below.
- R3: A tile passes its data-1 value when (select route value XOR select-invert bit) is 1, and its data-0 value otherwise.
- R4: Only tiles where x XOR y is odd own a flip-flop. On such a tile with the register enable set, the output equals the multiplexer result sampled at the previous rising edge of `clk`. On a tile without a flip-flop, the enable bit has no effect and the result appears in the same cycle.
- R5: Each flip-flop samples its multiplexer result on every rising edge, whether or not the enable bit is set. When `rst_n` is low at a rising edge, the flip-flop is cleared to 0.
- R6: On the left edge, L is `usr_in[y]` for rows 0..3 and `usr_in[3]` for row 4. On the top edge, T is `usr_in[x]`.
- R7: On the right edge, R is the tile's own output. On the bottom edge, B is the tile's own output.
- R8: `fab_out[x]` is the bottom-row tile at column x, and `fab_out[3+y]` is the right-column tile at row y. Unregistered paths reach the pins within the same cycle.
- R9: After reset with an all-zero configuration and all-zero user inputs, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock for the tile flip-flops |
| rst_n | input | 1 | Synchronous active-low clear of the tile flip-flops |
| cfg_bits | input | 120 | Flat configuration vector, frame-major, 12 bits per frame |
| usr_in | input | 4 | User inputs feeding the left and top edges |
| fab_out | output | 8 | Bottom-row outputs in [2:0], right-column outputs in [7:3] |

## Verification
An unregistered path reaches the pins in the same cycle as its stimulus. A registered tile shows its new value only after the next rising edge, and a reset shows its effect only after the rising edge at which `rst_n` was low. The bench changes `cfg_bits`, `usr_in` and `rst_n` just after a falling edge. It compares `fab_out` 1 ns later, when combinational paths have settled and no edge has passed. Its reference model steps its own copy of each flip-flop at the following rising edge, so a registered result is expected one check after the stimulus that produced it. Random configurations keep unregistered tiles on the up and left sources only, so no unregistered loop can form.

// File: rtl/fab_pkg.sv
// Package: shared parameters, route codes and the per-tile configuration
// record of the MUX2 tile array.
// Assumes: two-bit route fields; tile (x,y) owns a flip-flop when x^y is odd.
package fab_pkg;

    localparam int ROUTE_W = 2;

    // Decoded configuration of one tile
    typedef struct packed {
        logic               ff_en;
        logic               s_inv;
        logic [ROUTE_W-1:0] s_route;
        logic [ROUTE_W-1:0] i1_route;
        logic [ROUTE_W-1:0] i0_route;
    } tile_cfg_t;

    // Route codes shared by the data-0 and select inputs
    localparam logic [ROUTE_W-1:0] RT_CONST = 2'd0;
    localparam logic [ROUTE_W-1:0] RT_UP    = 2'd1;
    localparam logic [ROUTE_W-1:0] RT_RIGHT = 2'd2;
    localparam logic [ROUTE_W-1:0] RT_LEFT  = 2'd3;

    // Route codes of the data-1 input
    localparam logic [ROUTE_W-1:0] RT1_ONE   = 2'd0;
    localparam logic [ROUTE_W-1:0] RT1_NLEFT = 2'd1;
    localparam logic [ROUTE_W-1:0] RT1_DOWN  = 2'd2;
    localparam logic [ROUTE_W-1:0] RT1_RIGHT = 2'd3;

    // True when the tile at (x,y) owns a flip-flop (checkerboard)
    function automatic bit tile_has_ff(input int x, input int y);
        return ((x ^ y) & 1) == 1;
    endfunction

endpackage

// File: rtl/fab_cfg_slice.sv
// Module: fab_cfg_slice
// Unpacks the two 4-bit nibbles a tile owns into its configuration record.
// Assumes: lo_nib comes from the even frame of the tile's pair and hi_nib
// from the odd frame, both at the tile's column offset.
module fab_cfg_slice
    import fab_pkg::*;
(
    input  logic [3:0] lo_nib,
    input  logic [3:0] hi_nib,
    output tile_cfg_t  tcfg
);

    // Field unpacking, lower bit index is the field LSB
    always_comb begin
        tcfg.i0_route = lo_nib[1:0];
        tcfg.i1_route = lo_nib[3:2];
        tcfg.s_route  = hi_nib[1:0];
        tcfg.s_inv    = hi_nib[2];
        tcfg.ff_en    = hi_nib[3];
    end

endmodule

// File: rtl/fab_tile.sv
// Module: fab_tile
// One array tile: three route selectors feed a MUX2 and an optional
// flip-flop sits on the output path.
// Assumes: neighbour inputs are already resolved for edges by the parent;
// HAS_FF picks the variant; the flop clears synchronously on rst_n low.
module fab_tile
    import fab_pkg::*;
#(
    parameter bit HAS_FF = 1'b0
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tile_cfg_t tcfg,
    input  logic      nb_t,
    input  logic      nb_l,
    input  logic      nb_r,
    input  logic      nb_b,
    output logic      tile_out
);

    logic d0;
    logic d1;
    logic s_raw;
    logic sel;
    logic mux_d;

    // Data-0 source selection
    always_comb begin
        unique case (tcfg.i0_route)
            RT_CONST: d0 = 1'b0;
            RT_UP:    d0 = nb_t;
            RT_RIGHT: d0 = nb_r;
            default:  d0 = nb_l;
        endcase
    end

    // Data-1 source selection
    always_comb begin
        unique case (tcfg.i1_route)
            RT1_ONE:   d1 = 1'b1;
            RT1_NLEFT: d1 = ~nb_l;
            RT1_DOWN:  d1 = nb_b;
            default:   d1 = nb_r;
        endcase
    end

    // Select source selection
    always_comb begin
        unique case (tcfg.s_route)
            RT_CONST: s_raw = 1'b0;
            RT_UP:    s_raw = nb_t;
            RT_RIGHT: s_raw = nb_r;
            default:  s_raw = nb_l;
        endcase
    end

    assign sel   = s_raw ^ tcfg.s_inv;
    assign mux_d = sel ? d1 : d0;

    generate
        if (HAS_FF) begin : g_ff
            logic q;

            // Output flop samples the MUX result on every user clock edge
            always_ff @(posedge clk) begin
                if (!rst_n) q <= 1'b0;
                else        q <= mux_d;
            end

            assign tile_out = tcfg.ff_en ? q : mux_d;

            // R4: registered output is last cycle's MUX result
            assert_reg_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (tcfg.ff_en && $past(rst_n)) |-> (tile_out == $past(mux_d)));

            // R5: flop is clear right after a reset edge
            assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(rst_n) |-> (q == 1'b0));
        end else begin : g_comb
            logic unused_tile;
            assign tile_out    = mux_d;
            assign unused_tile = ^{clk, rst_n, tcfg.ff_en};
        end
    endgenerate

    // R2: constant routes reach an unregistered output unchanged
    always_comb begin
        if (!(HAS_FF && tcfg.ff_en)) begin
            if (tcfg.i0_route == RT_CONST && tcfg.s_route == RT_CONST && !tcfg.s_inv)
                assert_const_src_R2: assert (tile_out == 1'b0);
            if (tcfg.i1_route == RT1_ONE && tcfg.s_route == RT_CONST && tcfg.s_inv)
                assert_const_one_R2: assert (tile_out == 1'b1);
        end
    end

endmodule

// File: rtl/mux_fabric.sv
// Module: mux_fabric
// Top of the tile array: slices the configuration vector per tile, wires
// every tile to its neighbours, fills edge neighbours from user inputs or
// loopback, and maps bottom-row and right-column tiles to the output pins.
// Assumes: COLS <= NUM_IN (top edge indexes usr_in by column); the user
// loads no configuration that closes an unregistered loop.
module mux_fabric
    import fab_pkg::*;
#(
    parameter int COLS   = 3,
    parameter int ROWS   = 5,
    parameter int NUM_IN = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2*ROWS*4*COLS-1:0]     cfg_bits,
    input  logic [NUM_IN-1:0]            usr_in,
    output logic [COLS+ROWS-1:0]         fab_out
);

    localparam int FRAME_BITS = 4 * COLS;
    localparam int NUM_TILES  = COLS * ROWS;

    logic [NUM_TILES-1:0] t_out;
    tile_cfg_t            tcfg_a [NUM_TILES];

    generate
        for (genvar y = 0; y < ROWS; y++) begin : g_row
            for (genvar x = 0; x < COLS; x++) begin : g_col
                localparam int K  = y * COLS + x;
                localparam int LO = (2 * y) * FRAME_BITS + 4 * x;
                localparam int HI = (2 * y + 1) * FRAME_BITS + 4 * x;
                localparam int LI = (y < NUM_IN) ? y : NUM_IN - 1;

                logic nt;
                logic nl;
                logic nr;
                logic nb;

                if (y == 0) begin : g_top
                    assign nt = usr_in[x];
                end else begin : g_up
                    assign nt = t_out[K - COLS];
                end

                if (x == 0) begin : g_left
                    assign nl = usr_in[LI];
                end else begin : g_lnb
                    assign nl = t_out[K - 1];
                end

                if (x == COLS - 1) begin : g_right
                    assign nr = t_out[K];
                end else begin : g_rnb
                    assign nr = t_out[K + 1];
                end

                if (y == ROWS - 1) begin : g_bottom
                    assign nb = t_out[K];
                end else begin : g_bnb
                    assign nb = t_out[K + COLS];
                end

                fab_cfg_slice u_slice (
                    .lo_nib (cfg_bits[LO +: 4]),
                    .hi_nib (cfg_bits[HI +: 4]),
                    .tcfg   (tcfg_a[K])
                );

                fab_tile #(
                    .HAS_FF (tile_has_ff(x, y))
                ) u_tile (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .tcfg     (tcfg_a[K]),
                    .nb_t     (nt),
                    .nb_l     (nl),
                    .nb_r     (nr),
                    .nb_b     (nb),
                    .tile_out (t_out[K])
                );
            end
        end

        // Bottom row drives the low output pins, one per column
        for (genvar x = 0; x < COLS; x++) begin : g_out_bot
            assign fab_out[x] = t_out[(ROWS - 1) * COLS + x];
        end

        // Right column drives the upper output pins, one per row
        for (genvar y = 0; y < ROWS; y++) begin : g_out_rgt
            assign fab_out[COLS + y] = t_out[y * COLS + COLS - 1];
        end

        // R7: a registered right-edge tile selecting its own output inverts each edge
        if (ROWS > 1 && tile_has_ff(COLS - 1, 1)) begin : g_chk_toggle
            localparam int KT = COLS + COLS - 1;
            logic tog_cfg;
            assign tog_cfg = tcfg_a[KT].ff_en && tcfg_a[KT].s_inv
                          && tcfg_a[KT].s_route == RT_RIGHT
                          && tcfg_a[KT].i0_route == RT_CONST
                          && tcfg_a[KT].i1_route == RT1_ONE;
            assert_loop_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (tog_cfg && $past(tog_cfg) && $past(rst_n))
                |-> (fab_out[COLS + 1] != $past(fab_out[COLS + 1])));
        end

        // R6: bottom-left tile routing L straight through shows the last user input
        if (!tile_has_ff(0, ROWS - 1)) begin : g_chk_corner
            localparam int KC = (ROWS - 1) * COLS;
            localparam int LC = (ROWS - 1 < NUM_IN) ? ROWS - 1 : NUM_IN - 1;
            always_comb begin
                if (tcfg_a[KC].i0_route == RT_LEFT && tcfg_a[KC].s_route == RT_CONST
                    && !tcfg_a[KC].s_inv)
                    assert_left_corner_R6: assert (fab_out[0] == usr_in[LC]);
            end
        end
    endgenerate

endmodule

// File: tb/mux_fabric_bench.sv
module mux_fabric_bench;

    localparam int COLS = 3;
    localparam int ROWS = 5;
    localparam int NIN  = 4;
    localparam int FB   = 4 * COLS;
    localparam int CW   = 2 * ROWS * FB;
    localparam int NT   = COLS * ROWS;
    localparam int NO   = COLS + ROWS;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [CW-1:0] cfg;
    logic [NIN-1:0] uin;
    logic [NO-1:0] fout;

    logic [NT-1:0] mq;
    logic [NT-1:0] mux_v;
    logic [NT-1:0] out_v;
    logic [NO-1:0] exp_out;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    always #5 clk = ~clk;

    mux_fabric u_mux_fabric (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_bits (cfg),
        .usr_in   (uin),
        .fab_out  (fout)
    );

    function automatic bit hasff(int x, int y);
        return ((x ^ y) & 1) == 1;
    endfunction

    function automatic bit is_reg(int x, int y);
        return hasff(x, y) && cfg[(2 * y + 1) * FB + 4 * x + 3];
    endfunction

    // Reference MUX result of tile (x,y) from R1, R2, R3, R6, R7
    function automatic logic tile_mux(int x, int y);
        int k = y * COLS + x;
        logic t, l, r, b, i0v, i1v, sv;
        logic [1:0] c0, c1, cs;
        logic si;
        t  = (y == 0) ? uin[x] : out_v[k - COLS];
        l  = (x == 0) ? uin[(y < NIN) ? y : NIN - 1] : out_v[k - 1];
        r  = (x == COLS - 1) ? out_v[k] : out_v[k + 1];
        b  = (y == ROWS - 1) ? out_v[k] : out_v[k + COLS];
        c0 = cfg[(2 * y) * FB + 4 * x +: 2];
        c1 = cfg[(2 * y) * FB + 4 * x + 2 +: 2];
        cs = cfg[(2 * y + 1) * FB + 4 * x +: 2];
        si = cfg[(2 * y + 1) * FB + 4 * x + 2];
        case (c0) 2'd0: i0v = 1'b0; 2'd1: i0v = t; 2'd2: i0v = r; default: i0v = l; endcase
        case (c1) 2'd0: i1v = 1'b1; 2'd1: i1v = ~l; 2'd2: i1v = b; default: i1v = r; endcase
        case (cs) 2'd0: sv = 1'b0; 2'd1: sv = t; 2'd2: sv = r; default: sv = l; endcase
        return (sv ^ si) ? i1v : i0v;
    endfunction

    // Settles the model: registered tiles first, then unregistered in grid order
    task automatic model_eval();
        out_v = '0;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++)
                if (is_reg(x, y)) out_v[y * COLS + x] = mq[y * COLS + x];
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++)
                if (!is_reg(x, y)) out_v[y * COLS + x] = tile_mux(x, y);
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++)
                mux_v[y * COLS + x] = tile_mux(x, y);
        for (int x = 0; x < COLS; x++) exp_out[x] = out_v[(ROWS - 1) * COLS + x];
        for (int y = 0; y < ROWS; y++) exp_out[COLS + y] = out_v[y * COLS + COLS - 1];
    endtask

    task automatic check(string tag);
        total++;
        if (fout !== exp_out) begin
            bad++;
            $display("FAIL %s: fab_out=%h expected=%h", tag, fout, exp_out);
        end
    endtask

    // One cycle: inputs were set after a falling edge; check, then clock the model
    task automatic cycle(string tag);
        #1;
        model_eval();
        check(tag);
        @(posedge clk);
        for (int k = 0; k < NT; k++)
            if (hasff(k % COLS, k / COLS)) mq[k] = rst_n ? mux_v[k] : 1'b0;
        @(negedge clk);
    endtask

    task automatic put_tile(int x, int y, logic [1:0] i0, logic [1:0] i1,
                            logic [1:0] s, logic si, logic ff);
        cfg[(2 * y) * FB + 4 * x +: 2]     = i0;
        cfg[(2 * y) * FB + 4 * x + 2 +: 2] = i1;
        cfg[(2 * y + 1) * FB + 4 * x +: 2] = s;
        cfg[(2 * y + 1) * FB + 4 * x + 2]  = si;
        cfg[(2 * y + 1) * FB + 4 * x + 3]  = ff;
    endtask

    // Loop-free random configuration: unregistered tiles use up/left only
    task automatic rand_cfg();
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++) begin
                logic [1:0] a, s;
                if (hasff(x, y) && ($urandom % 2 == 1)) begin
                    put_tile(x, y, 2'($urandom), 2'($urandom), 2'($urandom),
                             1'($urandom), 1'b1);
                end else begin
                    a = 2'($urandom % 3); if (a == 2'd2) a = 2'd3;
                    s = 2'($urandom % 3); if (s == 2'd2) s = 2'd3;
                    put_tile(x, y, a, 2'($urandom % 2), s, 1'($urandom),
                             hasff(x, y) ? 1'b0 : 1'($urandom));
                end
            end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, got none expected end");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 1'b0;
        cfg   = '0;
        uin   = '0;
        mq    = '0;
        @(negedge clk);

        // R9: reset state with zero configuration
        for (int i = 0; i < 3; i++) cycle("R9");
        rst_n = 1'b1;
        cycle("R9");

        // R6: left-edge rows and top-edge columns reach the pins
        cfg = '0;
        put_tile(0, 4, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(2, 0, 2'd1, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(0, 1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(1, 1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(2, 1, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        for (int v = 0; v < 16; v++) begin
            uin = 4'(v);
            cycle("R6");
        end

        // R7: right-edge toggle cell and bottom-edge hold cell
        cfg = '0;
        put_tile(2, 1, 2'd0, 2'd0, 2'd2, 1'b1, 1'b1);
        put_tile(1, 4, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) cycle("R7");
        put_tile(1, 4, 2'd0, 2'd2, 2'd0, 1'b1, 1'b1);
        for (int i = 0; i < 8; i++) begin
            uin = 4'($urandom);
            cycle("R7");
        end

        // R4: unregistered corner vs registered right-column path, and
        // enable bit on a tile without a flip-flop
        cfg = '0;
        put_tile(0, 4, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1);
        put_tile(0, 3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(1, 3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        put_tile(2, 3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1);
        for (int i = 0; i < 10; i++) begin
            uin = (i % 2 == 0) ? 4'h8 : 4'h0;
            cycle("R4");
        end

        // R5: flop samples while disabled, then shows that value when enabled
        put_tile(2, 3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b0);
        uin = 4'h8;
        cycle("R5");
        put_tile(2, 3, 2'd3, 2'd0, 2'd0, 1'b0, 1'b1);
        uin = 4'h0;
        cycle("R5");
        cycle("R5");

        // R5: synchronous clear while the MUX result is 1
        cfg = '0;
        for (int y = 0; y < ROWS; y++)
            for (int x = 0; x < COLS; x++)
                if (hasff(x, y)) put_tile(x, y, 2'd0, 2'd0, 2'd0, 1'b1, 1'b1);
        cycle("R5");
        cycle("R5");
        rst_n = 1'b0;
        cycle("R5");
        rst_n = 1'b1;
        cycle("R5");
        cycle("R5");

        // Random mix: R1 R2 R3 R8 field layout, routes, select and pin map
        for (int i = 0; i < 600; i++) begin
            if (i % 8 == 0) rand_cfg();
            uin   = 4'($urandom);
            rst_n = ($urandom % 50 != 0);
            cycle("R1 R2 R3 R8");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule